// File: doc/BRIEF.md
# Destination Address Accept Filter

This block sits in the receive path and gives one verdict per received destination MAC address: keep the frame or drop it. An address is kept when it equals the programmed station address exactly, when it is the all-ones broadcast address, when it is a group address whose hash lands on a set bit of a 256-entry group table, or whenever the promiscuous control bit is set.

The hash is a CRC-32 over the six address bytes. Its top eight bits form the table index. The table is held as eight 32-bit configuration words, numbered MSB-first. A simple write-only register port loads the station address, the control bit and the table words. Each address arrives with a one-cycle strobe, and the verdict comes out with its own strobe a fixed number of cycles later. The parameter `PIPE` chooses one or two register stages.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset `out_valid` is low, the group table holds all zeros and promiscuous mode is off, so a non-broadcast group address is rejected.
- R2: With the default `PIPE` = 1, `out_valid` is high exactly two cycles after each cycle in which `in_valid` is high, and is low otherwise.
- R3: The table index is bits [31:24] of a CRC computed as follows. The register starts as all ones and shifts left. The polynomial is 0x04C11DB7. The bytes are fed in the order `in_dst[47:40]` (first byte) down to `in_dst[7:0]`, each byte least-significant bit first. No final inversion is applied.
- R4: For table index n, the lookup uses table word n[7:5] (write address 8 + n[7:5]) at bit position 31 − n[4:0]. Entry 0 is bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R5: For an address with bytes b0..b5 (b0 in `in_dst[47:40]`), the station address is loaded at write address 0 as {b5,b4,b3,b2} and at write address 1 as {b1,b0} in bits [31:16]. Bits [15:0] of address 1 are ignored.
- R6: A unicast address (bit 40 clear) that equals the station address is accepted.
- R7: A unicast address that differs from the station address is rejected when promiscuous mode is off.
- R8: The group table is consulted only when bit 40 of `in_dst` is set. A unicast address whose hash bit is set is still rejected unless it matches the station address.
- R9: Bit 3 of write address 2 enables promiscuous mode, in which every address is accepted. Clearing that bit restores filtering.
- R10: The broadcast address 48'hFFFF_FFFF_FFFF is accepted even when the table is empty.
- R11: Writes to addresses 3 to 7 change neither the filter settings nor the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Destination address strobe |
| in_dst | input | 48 | Destination address, first byte in [47:40] |
| out_valid | output | 1 | Verdict strobe |
| out_accept | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
A fault in the CRC or in the table bit mapping shows up as a group address that is accepted only when a neighbouring table bit is set. The bench exposes this by setting exactly one bit, then the mirrored bit, and checking the verdict two cycles after the strobe. A station word stored with its bytes swapped turns the exact-match accept into a reject on the very next probe. A stuck promiscuous or broadcast path makes an unrelated unicast address pass at the first verdict. Because every stage is checked with a strobe, a pipeline slip appears as a missing or extra `out_valid` on the cycle right after the expected one.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int MAC_BYTES  = 6;
   localparam int MAC_W      = MAC_BYTES * 8;
   localparam int CRC_W      = 32;
   localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
   localparam int CFG_AW     = 4;
   localparam logic [CFG_AW-1:0] A_STN_LO  = 4'd0;
   localparam logic [CFG_AW-1:0] A_STN_HI  = 4'd1;
   localparam logic [CFG_AW-1:0] A_CTRL    = 4'd2;
   localparam int TBL_BASE   = 8;
   localparam int PROMISC_BIT = 3;
   localparam int GROUP_BIT  = MAC_W - 8;
endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
   import daf_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [MAC_W-1:0]  stn_addr,
   output logic              promisc,
   output logic [(1<<IDX_W)-1:0] entry_vec
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int NREG    = ENTRIES / REG_W;
   localparam int SEL_W   = (NREG > 1) ? $clog2(NREG) : 1;

   logic [31:0] stn_lo;
   logic [15:0] stn_hi;
   logic [REG_W-1:0] tbl [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stn_lo  <= '0;
         stn_hi  <= '0;
         promisc <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr == A_STN_LO) stn_lo  <= cfg_wdata[31:0];
         if (cfg_addr == A_STN_HI) stn_hi  <= cfg_wdata[31:16];
         if (cfg_addr == A_CTRL)   promisc <= cfg_wdata[PROMISC_BIT];
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n)
            tbl[r] <= '0;
         else if (cfg_we && (int'(cfg_addr) == TBL_BASE + r))
            tbl[r] <= cfg_wdata;
      end
   end

   // index n: word n / REG_W, bit counted from the MSB
   for (genvar n = 0; n < ENTRIES; n++) begin : g_map
      assign entry_vec[n] = tbl[n / REG_W][REG_W - 1 - (n % REG_W)];
   end

   // bytes b0..b5, b0 first on the wire
   assign stn_addr = {stn_hi[7:0], stn_hi[15:8],
                      stn_lo[7:0], stn_lo[15:8], stn_lo[23:16], stn_lo[31:24]};

   logic [SEL_W-1:0] unused_sel;
   assign unused_sel = '0;

   // R1: table words clear out of reset
   p_tbl_reset_r1: assert property (@(posedge clk)
      $fell(rst_n) |=> (tbl[0] == '0) && !promisc);
endmodule

// File: rtl/daf_crc_hash.sv
module daf_crc_hash
   import daf_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic [MAC_W-1:0] addr,
   output logic [IDX_W-1:0] idx
);
   logic [CRC_W-1:0] crc;

   always_comb begin
      logic fb;
      crc = '1;
      fb  = 1'b0;
      for (int b = 0; b < MAC_BYTES; b++) begin
         for (int k = 0; k < 8; k++) begin
            fb  = crc[CRC_W-1] ^ addr[(MAC_BYTES-1-b)*8 + k];
            crc = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
         end
      end
   end

   assign idx = crc[CRC_W-1 -: IDX_W];
endmodule

// File: rtl/daf_decide.sv
module daf_decide
   import daf_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int PIPE  = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [MAC_W-1:0]      in_dst,
   input  logic [IDX_W-1:0]      idx,
   input  logic [MAC_W-1:0]      stn_addr,
   input  logic                  promisc,
   input  logic [(1<<IDX_W)-1:0] entry_vec,
   output logic                  out_valid,
   output logic                  out_accept
);
   logic grp_now, bc_now, st_now;
   assign grp_now = in_dst[GROUP_BIT];
   assign bc_now  = &in_dst;
   assign st_now  = (in_dst == stn_addr);

   if (PIPE != 0) begin : g_two
      logic             s_vld, s_grp, s_bc, s_st;
      logic [IDX_W-1:0] s_idx;
      logic             s_hit;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_vld <= 1'b0;
            s_grp <= 1'b0;
            s_bc  <= 1'b0;
            s_st  <= 1'b0;
            s_idx <= '0;
         end else begin
            s_vld <= in_valid;
            s_grp <= grp_now;
            s_bc  <= bc_now;
            s_st  <= st_now;
            s_idx <= idx;
         end
      end

      assign s_hit = entry_vec[s_idx];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
         end else begin
            out_valid  <= s_vld;
            out_accept <= s_vld & (promisc | s_bc | s_st | (s_grp & s_hit));
         end
      end

      // R7: unicast miss with filtering on is dropped
      p_ucast_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
         s_vld && !s_grp && !s_st && !promisc |=> out_valid && !out_accept);
      // R9: promiscuous keeps everything
      p_promisc_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
         s_vld && promisc |=> out_accept);
   end else begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
         end else begin
            out_valid  <= in_valid;
            out_accept <= in_valid &
                          (promisc | bc_now | st_now | (grp_now & entry_vec[idx]));
         end
      end
   end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
   import daf_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int IDX_W = 8,
   parameter int PIPE  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              in_valid,
   input  logic [47:0]       in_dst,
   output logic              out_valid,
   output logic              out_accept
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int NREG    = ENTRIES / REG_W;

   if (REG_W != 32)
      $error("REG_W must match the 32-bit write port");
   if (IDX_W < 5 || IDX_W > 8)
      $error("IDX_W out of range");
   if (NREG * REG_W != ENTRIES || TBL_BASE + NREG > 16)
      $error("table words do not fit the address map");
   if (PIPE < 0 || PIPE > 1)
      $error("PIPE must be 0 or 1");

   logic [MAC_W-1:0]   stn_addr;
   logic               promisc;
   logic [ENTRIES-1:0] entry_vec;
   logic [IDX_W-1:0]   idx;

   daf_cfg_regs #(.REG_W(REG_W), .IDX_W(IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .stn_addr(stn_addr), .promisc(promisc),
      .entry_vec(entry_vec));

   daf_crc_hash #(.IDX_W(IDX_W)) u_hash (
      .addr(in_dst), .idx(idx));

   daf_decide #(.IDX_W(IDX_W), .PIPE(PIPE)) u_dec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
      .idx(idx), .stn_addr(stn_addr), .promisc(promisc),
      .entry_vec(entry_vec), .out_valid(out_valid), .out_accept(out_accept));

   if (PIPE != 0) begin : g_chk2
      // R2: strobe in, verdict two cycles later
      p_lat_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> ##2 out_valid);
      p_lat_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $past(in_valid, 2));
      // R10: broadcast always kept
      p_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && (&in_dst) |-> ##2 out_accept);
   end else begin : g_chk1
      p_lat_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      p_bcast_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && (&in_dst) |=> out_accept);
   end
endmodule

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [47:0] in_dst = '0;
   logic        out_valid, out_accept;

   int n_chk = 0;
   int n_bad = 0;
   localparam int LAT = 2;

   always #4 clk = ~clk;

   dst_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_dst(in_dst),
      .out_valid(out_valid), .out_accept(out_accept));

   function automatic logic [7:0] ref_idx(input logic [47:0] a);
      logic [31:0] c;
      logic fb;
      c = '1;
      for (int b = 0; b < 6; b++)
         for (int k = 0; k < 8; k++) begin
            fb = c[31] ^ a[(5-b)*8 + k];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end
      return c[31:24];
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clr_tbl();
      for (int r = 0; r < 8; r++) wr(8 + r, 32'h0);
   endtask

   task automatic probe(input logic [47:0] a, input logic exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_dst = a;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      check(out_valid, 1'b1, {tag, " valid"});
      check(out_accept, exp, tag);
   endtask

   task automatic set_entry(input logic [7:0] n);
      wr(8 + int'(n[7:5]), 32'h1 << (31 - int'(n[4:0])));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(out_valid, 1'b0, "R1 idle valid");
      probe(48'h0100_5E00_0001, 1'b0, "R1 empty table drops group");
   endtask

   task automatic t_latency();
      @(negedge clk);
      in_valid = 1'b1; in_dst = 48'hFFFF_FFFF_FFFF;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid, 1'b0, "R2 not yet after one cycle");
      @(negedge clk);
      check(out_valid, 1'b1, "R2 valid after two cycles");
      @(negedge clk);
      check(out_valid, 1'b0, "R2 single-cycle strobe");
   endtask

   task automatic t_station();
      wr(0, 32'h5544_3322);
      wr(1, 32'h1102_ABCD);
      probe(48'h0211_2233_4455, 1'b1, "R5 R6 station match");
      probe(48'h1102_2233_4455, 1'b0, "R5 swapped upper bytes");
      probe(48'h0211_2233_4456, 1'b0, "R7 unicast miss");
   endtask

   task automatic t_hash();
      logic [47:0] a;
      logic [7:0]  n;
      a = 48'h0100_5E00_00FB;
      n = ref_idx(a);
      set_entry(n);
      probe(a, 1'b1, "R3 hashed group accepted");
      clr_tbl();
      wr(8 + int'(n[7:5]), 32'h1 << int'(n[4:0]));
      probe(a, 1'b0, "R4 mirrored bit does not hit");
      clr_tbl();
   endtask

   task automatic t_corner();
      logic [47:0] a0, a255;
      logic f0, f255;
      f0 = 1'b0; f255 = 1'b0; a0 = '0; a255 = '0;
      for (int k = 0; k < 65536; k++) begin
         logic [47:0] c;
         logic [7:0]  n;
         c = {8'h01, 24'h0, 16'(k)};
         n = ref_idx(c);
         if (!f0 && n == 8'd0)   begin a0 = c;   f0 = 1'b1; end
         if (!f255 && n == 8'hFF) begin a255 = c; f255 = 1'b1; end
      end
      wr(8, 32'h8000_0000);
      probe(a0, 1'b1, "R4 entry 0 is MSB of word 0");
      probe(a255, 1'b0, "R4 entry 255 clear");
      wr(8, 32'h0);
      wr(15, 32'h0000_0001);
      probe(a255, 1'b1, "R4 entry 255 is LSB of word 7");
      probe(a0, 1'b0, "R4 entry 0 cleared");
      clr_tbl();
   endtask

   task automatic t_ucast_hash();
      logic [47:0] u;
      u = 48'h0A00_0000_0001;
      set_entry(ref_idx(u));
      probe(u, 1'b0, "R8 unicast ignores table");
      clr_tbl();
   endtask

   task automatic t_promisc();
      wr(2, 32'h0000_0008);
      probe(48'h0A00_0000_0001, 1'b1, "R9 promiscuous unicast");
      probe(48'h0300_0000_0007, 1'b1, "R9 promiscuous group");
      wr(2, 32'h0);
      probe(48'h0A00_0000_0001, 1'b0, "R9 promiscuous off");
   endtask

   task automatic t_bcast();
      probe(48'hFFFF_FFFF_FFFF, 1'b1, "R10 broadcast");
   endtask

   task automatic t_unused();
      for (int a = 3; a < 8; a++) wr(a, 32'hFFFF_FFFF);
      probe(48'h0A00_0000_0001, 1'b0, "R11 unicast still filtered");
      probe(48'h0100_5E00_00FB, 1'b0, "R11 table untouched");
      probe(48'h0211_2233_4455, 1'b1, "R11 station untouched");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latency();
      t_station();
      t_hash();
      t_corner();
      t_ucast_hash();
      t_promisc();
      t_bcast();
      t_unused();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule